// File: doc/BRIEF.md
# Debug Bus Match Comparator

This block watches every cycle of a CPU bus and raises a one-cycle trigger when an access meets conditions that debug software has programmed. Four registers set the conditions: a control byte, a match address, a match data word and a per-bit data mask. A data match can be defined as equality or as inequality of the masked bits. The access size (byte or word) and the direction (read or write) can also be required to match. Matching and triggering happen only while the external armed flag is high.

In tag mode a matching opcode fetch does not trigger at once. The comparator records a tag bit for each fetched opcode in a small in-order queue that mirrors the instruction queue. When the execute indication pops a tagged entry, the trigger fires. A flush of the instruction queue discards every pending tag, so opcodes that never run produce no trigger.

A build parameter selects one of two control layouts for bit 6. In layout A it inverts the data comparison. In layout B it selects the access size to compare, and bit 7 enables that size check.

Top module: `bus_match_cmp`

## Requirements
- R1: After reset, all four registers read 0 and the trigger output is low.
- R2: Registers are selected by `reg_sel` (0 control, 1 address, 2 data, 3 mask). The address, data and mask registers accept writes at any time. A control write while `armed` is high is discarded. Control bits 1 and 4 always read 0, and so does bit 7 in layout A.
- R3: Control bit 0 enables the comparator and bit 5 selects tag mode. With bit 0 set, bit 5 clear and `armed` high, an access is a match when `bus_addr` equals the address register, the access passes the other enabled qualifiers and the masked data matches. A match makes `trig` high for exactly the one cycle after the bus cycle.
- R4: A data bit takes part in the comparison only where the mask register bit is 1. Mask bits that are 0 exclude their data bits.
- R5: Layout A: with control bit 6 set, the data condition holds when the masked bus data differs from the data register.
- R6: Layout B: with control bit 7 set, the access must have `bus_byte` equal to control bit 6 (1 byte, 0 word). With bit 7 clear, size is ignored.
- R7: With control bit 2 set, only accesses whose `bus_rd` equals control bit 3 (1 read, 0 write) can match.
- R8: No trigger and no tag are produced while control bit 0 is 0 or `armed` is low.
- R9: In tag mode, a fetch (`bus_fetch` high) at the match address that passes the read/write qualifier tags that opcode. The size and data qualifiers and bit 6 are ignored, and no immediate trigger occurs. `trig` pulses in the cycle after `q_exec` retires the tagged opcode.
- R10: `q_flush` discards all pending tags, and a later execute of those opcodes does not trigger.
- R11: Tags retire in fetch order. Executing an untagged opcode fetched ahead of a tagged one does not trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | REG_W | Register write data |
| reg_rdata | output | REG_W | Selected register contents, zero-extended |
| armed | input | 1 | Debug session armed |
| bus_valid | input | 1 | Bus access present this cycle |
| bus_addr | input | ADDR_W | Access address |
| bus_data | input | DATA_W | Access data |
| bus_byte | input | 1 | 1 byte access, 0 word access |
| bus_rd | input | 1 | 1 read, 0 write |
| bus_fetch | input | 1 | Access is an opcode fetch |
| q_exec | input | 1 | Oldest queued opcode executes |
| q_flush | input | 1 | Instruction queue flushed |
| trig | output | 1 | Trigger pulse |

## Verification
The data comparison is tried with exact equal words, with a single-bit difference and with a difference confined to masked-off bits. This separates the equality, inversion and mask paths. Byte and word accesses are driven against both size settings, and reads against writes, so that each qualifier is shown to block and also to pass. Tag mode is driven with mismatching data and with inversion set, which shows those fields are ignored. Mixed tagged and untagged fetches then expose the retire order, and a flush between fetch and execute shows that discarded tags never trigger.

// File: rtl/bmc_pkg.sv
`timescale 1ns/1ps
package bmc_pkg;
  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_ADDR = 2'd1,
    SEL_DATA = 2'd2,
    SEL_MASK = 2'd3
  } reg_sel_e;

  // control byte, bit 7 down to bit 0
  typedef struct packed {
    logic sz_en;   // 7: size compare enable (layout B)
    logic b6;      // 6: data invert (A) / size value (B)
    logic tag;     // 5: tag mode
    logic rsv4;    // 4: reserved
    logic rw_val;  // 3: 1 read, 0 write
    logic rw_en;   // 2: direction compare enable
    logic rsv1;    // 1: reserved
    logic en;      // 0: comparator enable
  } ctrl_t;

  localparam int CTRL_W = 8;
endpackage

// File: rtl/bmc_regs.sv
`timescale 1ns/1ps
module bmc_regs
  import bmc_pkg::*;
#(
  parameter int ADDR_W  = 20,
  parameter int DATA_W  = 16,
  parameter int REG_W   = 20,
  parameter int VARIANT = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              armed,
  input  logic              reg_wr,
  input  logic [1:0]        reg_sel,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output ctrl_t             ctrl_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] data_q,
  output logic [DATA_W-1:0] mask_q
);
  localparam logic [CTRL_W-1:0] CTRL_IMPL = (VARIANT != 0) ? 8'hED : 8'h6D;

  logic        ctrl_we, addr_we, data_we, mask_we;
  ctrl_t       ctrl_d;

  always_comb begin
    ctrl_we = reg_wr && (reg_sel == SEL_CTRL) && !armed;
    addr_we = reg_wr && (reg_sel == SEL_ADDR);
    data_we = reg_wr && (reg_sel == SEL_DATA);
    mask_we = reg_wr && (reg_sel == SEL_MASK);
    ctrl_d  = ctrl_t'(reg_wdata[CTRL_W-1:0] & CTRL_IMPL);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_we) ctrl_q <= ctrl_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (addr_we) addr_q <= reg_wdata[ADDR_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_q <= '0;
    else if (data_we) data_q <= reg_wdata[DATA_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_we) mask_q <= reg_wdata[DATA_W-1:0];
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_sel)
      SEL_CTRL: reg_rdata[CTRL_W-1:0] = ctrl_q;
      SEL_ADDR: reg_rdata[ADDR_W-1:0] = addr_q;
      SEL_DATA: reg_rdata[DATA_W-1:0] = data_q;
      default:  reg_rdata[DATA_W-1:0] = mask_q;
    endcase
  end
endmodule

// File: rtl/bmc_match.sv
`timescale 1ns/1ps
module bmc_match
  import bmc_pkg::*;
#(
  parameter int ADDR_W  = 20,
  parameter int DATA_W  = 16,
  parameter int VARIANT = 0
) (
  input  ctrl_t             ctrl,
  input  logic [ADDR_W-1:0] addr_q,
  input  logic [DATA_W-1:0] data_q,
  input  logic [DATA_W-1:0] mask_q,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_data,
  input  logic              bus_byte,
  input  logic              bus_rd,
  output logic              addr_hit,
  output logic              full_hit
);
  logic [DATA_W-1:0] diff;
  logic              data_eq, data_ok, size_ok, rw_ok;
  logic              unused_rsv;

  assign unused_rsv = ^{ctrl.rsv1, ctrl.rsv4, ctrl.tag, ctrl.en};

  always_comb begin
    diff     = (bus_data ^ data_q) & mask_q;
    data_eq  = ~|diff;
    rw_ok    = !ctrl.rw_en || (bus_rd == ctrl.rw_val);
    addr_hit = (bus_addr == addr_q) && rw_ok;
  end

  generate
    if (VARIANT == 0) begin : g_layout_a
      logic unused_size;
      assign unused_size = ^{bus_byte, ctrl.sz_en};
      assign data_ok = ctrl.b6 ? !data_eq : data_eq;
      assign size_ok = 1'b1;
    end else begin : g_layout_b
      assign data_ok = data_eq;
      assign size_ok = !ctrl.sz_en || (bus_byte == ctrl.b6);
    end
  endgenerate

  assign full_hit = addr_hit && data_ok && size_ok;
endmodule

// File: rtl/bmc_tagq.sv
`timescale 1ns/1ps
module bmc_tagq #(
  parameter int Q_DEPTH = 4,
  parameter int CNT_W   = $clog2(Q_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             push_tag,
  input  logic             pop,
  input  logic             flush,
  output logic             head_tag,
  output logic [CNT_W-1:0] count
);
  logic [Q_DEPTH-1:0] tq_q, tq_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic               upd;

  always_comb begin
    tq_d  = tq_q;
    cnt_d = cnt_q;
    if (flush) begin
      tq_d  = '0;
      cnt_d = '0;
    end else begin
      if (pop && (cnt_q != '0)) begin
        for (int i = 0; i < Q_DEPTH - 1; i++) tq_d[i] = tq_q[i+1];
        tq_d[Q_DEPTH-1] = 1'b0;
        cnt_d = cnt_q - 1'b1;
      end
      if (push && (cnt_d < CNT_W'(Q_DEPTH))) begin
        for (int i = 0; i < Q_DEPTH; i++)
          if (CNT_W'(i) == cnt_d) tq_d[i] = push_tag;
        cnt_d = cnt_d + 1'b1;
      end
    end
    upd = flush || push || pop;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tq_q  <= '0;
      cnt_q <= '0;
    end else if (upd) begin
      tq_q  <= tq_d;
      cnt_q <= cnt_d;
    end
  end

  assign head_tag = (cnt_q != '0) && tq_q[0];
  assign count    = cnt_q;
endmodule

// File: rtl/bus_match_cmp.sv
`timescale 1ns/1ps
module bus_match_cmp
  import bmc_pkg::*;
#(
  parameter int ADDR_W  = 20,
  parameter int DATA_W  = 16,
  parameter int REG_W   = 20,
  parameter int Q_DEPTH = 4,
  parameter int VARIANT = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_sel,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              armed,
  input  logic              bus_valid,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_data,
  input  logic              bus_byte,
  input  logic              bus_rd,
  input  logic              bus_fetch,
  input  logic              q_exec,
  input  logic              q_flush,
  output logic              trig
);
  localparam int CNT_W = $clog2(Q_DEPTH + 1);

  logic [1:0]        rst_s;
  logic              rst_int_n;
  ctrl_t             ctrl_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q, mask_q;
  logic              addr_hit, full_hit, head_tag;
  logic              tag_push, tag_mark;
  logic              imm_hit, exe_hit, trig_d;
  logic [CNT_W-1:0]  tag_cnt;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_s <= 2'b00;
    else        rst_s <= {rst_s[0], 1'b1};
  end
  assign rst_int_n = rst_s[1];

  bmc_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_W(REG_W), .VARIANT(VARIANT)) u_regs (
    .clk(clk), .rst_n(rst_int_n), .armed(armed), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ctrl_q(ctrl_q), .addr_q(addr_q),
    .data_q(data_q), .mask_q(mask_q)
  );

  bmc_match #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .VARIANT(VARIANT)) u_match (
    .ctrl(ctrl_q), .addr_q(addr_q), .data_q(data_q), .mask_q(mask_q),
    .bus_addr(bus_addr), .bus_data(bus_data), .bus_byte(bus_byte), .bus_rd(bus_rd),
    .addr_hit(addr_hit), .full_hit(full_hit)
  );

  always_comb begin
    tag_push = bus_valid && bus_fetch;
    tag_mark = armed && ctrl_q.en && ctrl_q.tag && addr_hit;
    imm_hit  = bus_valid && !ctrl_q.tag && full_hit;
    exe_hit  = ctrl_q.tag && q_exec && !q_flush && head_tag;
    trig_d   = armed && ctrl_q.en && (imm_hit || exe_hit);
  end

  bmc_tagq #(.Q_DEPTH(Q_DEPTH), .CNT_W(CNT_W)) u_tagq (
    .clk(clk), .rst_n(rst_int_n), .push(tag_push), .push_tag(tag_mark),
    .pop(q_exec), .flush(q_flush), .head_tag(head_tag), .count(tag_cnt)
  );

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) trig <= 1'b0;
    else            trig <= trig_d;
  end
endmodule

// File: rtl/bus_match_cmp_chk.sv
`timescale 1ns/1ps
module bus_match_cmp_chk #(
  parameter int Q_DEPTH = 4,
  parameter int CNT_W   = $clog2(Q_DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             armed,
  input logic             reg_wr,
  input logic [1:0]       reg_sel,
  input logic             q_exec,
  input logic             q_flush,
  input logic             trig,
  input logic [7:0]       ctrl_bits,
  input logic [CNT_W-1:0] tag_cnt
);
  // R2: control byte frozen while armed
  a_r2_ctrl_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && reg_wr && reg_sel == 2'd0) |=> $stable(ctrl_bits));

  // R8: a trigger needs the armed flag one cycle earlier
  a_r8_needs_armed: assert property (@(posedge clk) disable iff (!rst_n)
    trig |-> $past(armed));

  // R8: a trigger needs the enable bit one cycle earlier
  a_r8_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    trig |-> $past(ctrl_bits[0]));

  // R9: in tag mode the trigger comes from an execute
  a_r9_tag_from_exec: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && ctrl_bits[5]) |-> $past(q_exec));

  // R10: flush leaves no pending tag
  a_r10_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    q_flush |=> (tag_cnt == '0));

  // R11: tag queue stays within its depth
  a_r11_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    tag_cnt <= CNT_W'(Q_DEPTH));
endmodule

bind bus_match_cmp bus_match_cmp_chk #(.Q_DEPTH(Q_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .armed(armed), .reg_wr(reg_wr), .reg_sel(reg_sel),
  .q_exec(q_exec), .q_flush(q_flush), .trig(trig), .ctrl_bits(ctrl_q), .tag_cnt(tag_cnt)
);

// File: tb/bus_match_cmp_bench.sv
`timescale 1ns/1ps
module bus_match_cmp_bench;
  localparam int ADDR_W = 20;
  localparam int DATA_W = 16;
  localparam int REG_W  = 20;
  localparam logic [ADDR_W-1:0] MA = 20'h01234;

  logic clk, rst_n;
  logic reg_wr;
  logic [1:0] reg_sel;
  logic [REG_W-1:0] reg_wdata, rdata_a, rdata_b;
  logic armed, bus_valid, bus_byte, bus_rd, bus_fetch, q_exec, q_flush;
  logic [ADDR_W-1:0] bus_addr;
  logic [DATA_W-1:0] bus_data;
  logic trig_a, trig_b;
  int checks, errors;

  initial clk = 1'b0;
  always #10 clk = ~clk;

  bus_match_cmp #(.VARIANT(0)) u_bus_match_cmp (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rdata(rdata_a), .armed(armed), .bus_valid(bus_valid), .bus_addr(bus_addr),
    .bus_data(bus_data), .bus_byte(bus_byte), .bus_rd(bus_rd), .bus_fetch(bus_fetch),
    .q_exec(q_exec), .q_flush(q_flush), .trig(trig_a));

  bus_match_cmp #(.VARIANT(1)) u_bus_match_cmp_szb (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rdata(rdata_b), .armed(armed), .bus_valid(bus_valid), .bus_addr(bus_addr),
    .bus_data(bus_data), .bus_byte(bus_byte), .bus_rd(bus_rd), .bus_fetch(bus_fetch),
    .q_exec(q_exec), .q_flush(q_flush), .trig(trig_b));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] sel, input logic [REG_W-1:0] val);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = val;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] sel, output logic [REG_W-1:0] a, output logic [REG_W-1:0] b);
    @(negedge clk);
    reg_sel = sel;
    #1;
    a = rdata_a; b = rdata_b;
  endtask

  // drive one access, return trigger in the following cycle
  task automatic bus_acc(input logic [ADDR_W-1:0] ad, input logic [DATA_W-1:0] dt,
                         input logic byt, input logic rd, input logic fe,
                         output logic ta, output logic tb);
    @(negedge clk);
    bus_valid = 1'b1; bus_addr = ad; bus_data = dt; bus_byte = byt; bus_rd = rd; bus_fetch = fe;
    @(negedge clk);
    ta = trig_a; tb = trig_b;
    bus_valid = 1'b0; bus_fetch = 1'b0;
  endtask

  task automatic exec_one(output logic ta);
    @(negedge clk);
    q_exec = 1'b1;
    @(negedge clk);
    ta = trig_a;
    q_exec = 1'b0;
  endtask

  task automatic setup(input logic [7:0] c, input logic [DATA_W-1:0] m);
    armed = 1'b0;
    reg_write(2'd0, REG_W'(c));
    reg_write(2'd3, REG_W'(m));
    armed = 1'b1;
  endtask

  task automatic t_reset;
    logic [REG_W-1:0] a, b;
    for (int s = 0; s < 4; s++) begin
      reg_read(2'(s), a, b);
      chk("R1 reg A", a, 0);
      chk("R1 reg B", b, 0);
    end
    chk("R1 trig", {trig_a, trig_b}, 0);
  endtask

  task automatic t_regs;
    logic [REG_W-1:0] a, b;
    armed = 1'b0;
    reg_write(2'd0, 20'h000FF);
    reg_read(2'd0, a, b);
    chk("R2 ctrl implemented bits A", a, 20'h6D);
    chk("R2 ctrl implemented bits B", b, 20'hED);
    armed = 1'b1;
    reg_write(2'd0, 20'h00000);
    reg_read(2'd0, a, b);
    chk("R2 ctrl write while armed discarded", a, 20'h6D);
    reg_write(2'd1, MA);
    reg_write(2'd2, 20'h000A5);
    reg_read(2'd1, a, b);
    chk("R2 addr write while armed", a, MA);
    reg_read(2'd2, a, b);
    chk("R2 data write while armed", a, 20'hA5);
  endtask

  task automatic t_equal;
    logic ta, tb;
    setup(8'h01, 16'hFFFF);
    bus_acc(MA, 16'h00A5, 1'b0, 1'b1, 1'b0, ta, tb);
    chk("R3 equal match", ta, 1);
    @(negedge clk);
    chk("R3 single cycle pulse", trig_a, 0);
    bus_acc(MA + 1, 16'h00A5, 1'b0, 1'b1, 1'b0, ta, tb);
    chk("R3 address miss", ta, 0);
    bus_acc(MA, 16'h00A4, 1'b0, 1'b1, 1'b0, ta, tb);
    chk("R3 data miss", ta, 0);
  endtask

  task automatic t_mask;
    logic ta, tb;
    setup(8'h01, 16'hFF00);
    bus_acc(MA, 16'h00FF, 1'b0, 1'b1, 1'b0, ta, tb);
    chk("R4 masked bits ignored", ta, 1);
    bus_acc(MA, 16'h01A5, 1'b0, 1'b1, 1'b0, ta, tb);
    chk("R4 compared bit differs", ta, 0);
  endtask

  task automatic t_ndb;
    logic ta, tb;
    setup(8'h41, 16'hFFFF);
    bus_acc(MA, 16'h00A5, 1'b0, 1'b1, 1'b0, ta, tb);
    chk("R5 invert equal no match", ta, 0);
    chk("R6 layout B size off equal", tb, 1);
    bus_acc(MA, 16'h00A6, 1'b0, 1'b1, 1'b0, ta, tb);
    chk("R5 invert differ match", ta, 1);
  endtask

  task automatic t_size;
    logic ta, tb;
    setup(8'hC1, 16'hFFFF);
    bus_acc(MA, 16'h00A5, 1'b1, 1'b1, 1'b0, ta, tb);
    chk("R6 byte selected byte access", tb, 1);
    bus_acc(MA, 16'h00A5, 1'b0, 1'b1, 1'b0, ta, tb);
    chk("R6 byte selected word access", tb, 0);
    setup(8'h81, 16'hFFFF);
    bus_acc(MA, 16'h00A5, 1'b0, 1'b1, 1'b0, ta, tb);
    chk("R6 word selected word access", tb, 1);
    bus_acc(MA, 16'h00A5, 1'b1, 1'b1, 1'b0, ta, tb);
    chk("R6 word selected byte access", tb, 0);
  endtask

  task automatic t_rw;
    logic ta, tb;
    setup(8'h0D, 16'hFFFF);
    bus_acc(MA, 16'h00A5, 1'b0, 1'b1, 1'b0, ta, tb);
    chk("R7 read only read", ta, 1);
    bus_acc(MA, 16'h00A5, 1'b0, 1'b0, 1'b0, ta, tb);
    chk("R7 read only write", ta, 0);
    setup(8'h05, 16'hFFFF);
    bus_acc(MA, 16'h00A5, 1'b0, 1'b0, 1'b0, ta, tb);
    chk("R7 write only write", ta, 1);
  endtask

  task automatic t_off;
    logic ta, tb;
    setup(8'h00, 16'hFFFF);
    bus_acc(MA, 16'h00A5, 1'b0, 1'b1, 1'b0, ta, tb);
    chk("R8 disabled", {ta, tb}, 0);
    setup(8'h01, 16'hFFFF);
    armed = 1'b0;
    bus_acc(MA, 16'h00A5, 1'b0, 1'b1, 1'b0, ta, tb);
    chk("R8 disarmed", {ta, tb}, 0);
    setup(8'h21, 16'hFFFF);
    armed = 1'b0;
    bus_acc(MA, 16'h00A5, 1'b0, 1'b1, 1'b1, ta, tb);
    armed = 1'b1;
    exec_one(ta);
    chk("R8 no tag while disarmed", ta, 0);
  endtask

  task automatic t_tag;
    logic ta, tb;
    setup(8'h61, 16'hFFFF);
    bus_acc(MA, 16'h1111, 1'b1, 1'b1, 1'b1, ta, tb);
    chk("R9 no immediate trigger", ta, 0);
    exec_one(ta);
    chk("R9 trigger on execute", ta, 1);
    exec_one(ta);
    chk("R9 empty queue execute", ta, 0);
    bus_acc(MA, 16'h00A5, 1'b0, 1'b1, 1'b0, ta, tb);
    exec_one(ta);
    chk("R9 non-fetch access not tagged", ta, 0);
  endtask

  task automatic t_order;
    logic ta, tb;
    setup(8'h21, 16'hFFFF);
    bus_acc(MA + 2, 16'h0000, 1'b0, 1'b1, 1'b1, ta, tb);
    bus_acc(MA, 16'h0000, 1'b0, 1'b1, 1'b1, ta, tb);
    exec_one(ta);
    chk("R11 untagged first", ta, 0);
    exec_one(ta);
    chk("R11 tagged second", ta, 1);
  endtask

  task automatic t_flush;
    logic ta, tb;
    setup(8'h21, 16'hFFFF);
    bus_acc(MA, 16'h0000, 1'b0, 1'b1, 1'b1, ta, tb);
    @(negedge clk);
    q_flush = 1'b1;
    @(negedge clk);
    q_flush = 1'b0;
    exec_one(ta);
    chk("R10 flushed tag no trigger", ta, 0);
  endtask

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    checks = 0; errors = 0;
    rst_n = 1'b0; reg_wr = 1'b0; reg_sel = 2'd0; reg_wdata = '0; armed = 1'b0;
    bus_valid = 1'b0; bus_addr = '0; bus_data = '0; bus_byte = 1'b0; bus_rd = 1'b0;
    bus_fetch = 1'b0; q_exec = 1'b0; q_flush = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset;
    t_regs;
    t_equal;
    t_mask;
    t_ndb;
    t_size;
    t_rw;
    t_off;
    t_tag;
    t_order;
    t_flush;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule